// File: doc/BRIEF.md
# Photometry Window Pulse Generator

This block produces a single active-high window pulse that marks the part of each field the exposure metering should weigh. It counts master clocks from every horizontal sync falling edge and lines from every vertical sync falling edge. It compares both counts against bounds that depend on the video standard (525-line or 625-line), on the sensor width (510 or 760 pixels per line) and on which field is being scanned. Two select inputs choose one of four weightings: the whole picture, the lower part, a central band, or the lower part and central band together.

The horizontal closing point is given as a distance before the next sync edge. The block therefore measures the length of each line and places the closing point relative to the last length it measured. The vertical line bounds are parameters whose defaults are the broadcast values. The horizontal clock bounds are fixed per standard and sensor width.

Top module: `meter_win`

## Requirements
- R1: While `rstN` is low, `winOut` is low, and it goes low as soon as `rstN` falls.
- R2: The window kind is decoded from {`selCenter`,`selBottom`}: 00 whole picture, 01 lower part, 10 central band, 11 lower part or central band.
- R3: Let h be the number of `hdIn` falling edges seen since the last `vdIn` falling edge (an `hdIn` edge in the same cycle as a `vdIn` edge is not counted). With `fieldEven` low, the whole-picture window is vertically open from h = FULL onwards (default FULL = 20 for 525-line, 25 for 625-line). With `fieldEven` high the bound is FULL+1. The window stays open until the next `vdIn` falling edge.
- R4: The central band is vertically open for MID_BEG+f <= h < MID_END+f, where f is `fieldEven`. The defaults are 101..181 for 525-line and 121..216 for 625-line.
- R5: The lower-part window is vertically open for h >= MID_END+f and stays open until the next `vdIn` falling edge.
- R6: With both selects high, `winOut` is the OR of the lower-part window and the central-band window, each with its own horizontal bounds.
- R7: For the whole-picture and lower-part windows, let p be the clocks since the last `hdIn` falling edge (0 in the edge cycle) and L the measured line length. The window is horizontally open for OPEN <= p < L-CLOSE. (OPEN,CLOSE) is (104,3) for 525-line/510, (154,22) for 525-line/760, (114,3) for 625-line/510 and (169,22) for 625-line/760.
- R8: For the central band, (OPEN,CLOSE) is (272,167) for 525-line/510, (407,252) for 525-line/760, (279,164) for 625-line/510 and (416,246) for 625-line/760.
- R9: L is the clock count between the two most recent `hdIn` falling edges. `winOut` stays low until two edges have been seen after reset. `winOut` is registered: it reflects the position, line count and select inputs one clock after they are sampled. `stdCcir` high selects 625-line and `wideSensor` high selects the 760 sensor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master pixel clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hdIn | input | 1 | Horizontal sync; the falling edge starts a line |
| vdIn | input | 1 | Vertical sync; the falling edge starts a field |
| fieldEven | input | 1 | High in the field whose bounds fall half a line later |
| stdCcir | input | 1 | Low: 525-line bounds, high: 625-line bounds |
| wideSensor | input | 1 | Low: 510-pixel sensor, high: 760-pixel sensor |
| selBottom | input | 1 | Window select, low bit |
| selCenter | input | 1 | Window select, high bit |
| winOut | output | 1 | Photometry window pulse, active high |

## Verification
A line counter that is off by one moves every vertical edge of the window by a full line. This shows at the output within the first field after a vertical sync, as a whole line of wrong window level. A wrong pixel count or measured length shifts the opening or closing point on every open line by the same number of clocks, so it is visible within one line of the window opening. Because every select and standard input is registered alongside the counters, a stage misaligned by a cycle appears as a one-clock step at each window edge. The bench compares every clock against its own arithmetic model, so such a step is caught.

// File: rtl/meter_win_pkg.sv
package meter_win_pkg;

  // Window kind as decoded from {selCenter, selBottom}
  typedef enum logic [1:0] {
    WIN_FULL   = 2'b00,
    WIN_BOTTOM = 2'b01,
    WIN_CENTER = 2'b10,
    WIN_BOTH   = 2'b11
  } winKind_e;

  // Strobes and qualifiers from the control to the datapath
  typedef struct packed {
    logic hdFall;  // horizontal sync falling edge this cycle
    logic enA;     // vertical qualifier, whole-picture / lower-part window
    logic enC;     // vertical qualifier, central band
    logic ccir;    // registered 625-line select
    logic wide;    // registered 760-pixel select
  } winStrb_t;

endpackage

// File: rtl/meter_win_ctl.sv
module meter_win_ctl
  import meter_win_pkg::*;
#(
  parameter int LINE_W       = 10,
  parameter int EIA_FULL_LN  = 20,
  parameter int EIA_MID_BEG  = 101,
  parameter int EIA_MID_END  = 181,
  parameter int CCIR_FULL_LN = 25,
  parameter int CCIR_MID_BEG = 121,
  parameter int CCIR_MID_END = 216
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     hdIn,
  input  logic     vdIn,
  input  logic     fieldEven,
  input  logic     stdCcir,
  input  logic     wideSensor,
  input  logic     selBottom,
  input  logic     selCenter,
  output winStrb_t strb
);

  localparam logic [LINE_W-1:0] LINE_MAX = '1;
  localparam logic [LINE_W-1:0] E_FULL = LINE_W'(EIA_FULL_LN);
  localparam logic [LINE_W-1:0] E_BEG  = LINE_W'(EIA_MID_BEG);
  localparam logic [LINE_W-1:0] E_END  = LINE_W'(EIA_MID_END);
  localparam logic [LINE_W-1:0] C_FULL = LINE_W'(CCIR_FULL_LN);
  localparam logic [LINE_W-1:0] C_BEG  = LINE_W'(CCIR_MID_BEG);
  localparam logic [LINE_W-1:0] C_END  = LINE_W'(CCIR_MID_END);

  logic hdQ, vdQ;
  logic hdFall, vdFall;
  logic halfQ, ccirQ, wideQ;
  winKind_e kindQ;
  logic [LINE_W-1:0] lineCnt;
  logic [LINE_W-1:0] fullAt, begAt, endAt;
  logic vFull, vMid, vLow;

  assign hdFall = hdQ & ~hdIn;
  assign vdFall = vdQ & ~vdIn;

  // Sync edge history, configuration capture and line counting
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hdQ     <= 1'b1;
      vdQ     <= 1'b1;
      halfQ   <= 1'b0;
      ccirQ   <= 1'b0;
      wideQ   <= 1'b0;
      kindQ   <= WIN_FULL;
      lineCnt <= '0;
    end else begin
      hdQ   <= hdIn;
      vdQ   <= vdIn;
      halfQ <= fieldEven;
      ccirQ <= stdCcir;
      wideQ <= wideSensor;
      kindQ <= winKind_e'({selCenter, selBottom});
      if (vdFall) begin
        lineCnt <= '0;
      end else if (hdFall && lineCnt != LINE_MAX) begin
        lineCnt <= lineCnt + 1'b1;
      end
    end
  end

  // Vertical bounds for the captured standard and field
  always_comb begin
    fullAt = (ccirQ ? C_FULL : E_FULL) + LINE_W'(halfQ);
    begAt  = (ccirQ ? C_BEG  : E_BEG ) + LINE_W'(halfQ);
    endAt  = (ccirQ ? C_END  : E_END ) + LINE_W'(halfQ);
    vFull  = lineCnt >= fullAt;
    vMid   = (lineCnt >= begAt) && (lineCnt < endAt);
    vLow   = lineCnt >= endAt;
  end

  always_comb begin
    strb.hdFall = hdFall;
    strb.ccir   = ccirQ;
    strb.wide   = wideQ;
    unique case (kindQ)
      WIN_FULL:   begin strb.enA = vFull; strb.enC = 1'b0; end
      WIN_BOTTOM: begin strb.enA = vLow;  strb.enC = 1'b0; end
      WIN_CENTER: begin strb.enA = 1'b0;  strb.enC = vMid; end
      default:    begin strb.enA = vLow;  strb.enC = vMid; end
    endcase
  end

endmodule

// File: rtl/meter_win_dp.sv
module meter_win_dp
  import meter_win_pkg::*;
#(
  parameter int PIX_W = 11
) (
  input  logic     clk,
  input  logic     rstN,
  input  winStrb_t strb,
  output logic     lenOk,
  output logic     winOut
);

  localparam logic [PIX_W-1:0] PIX_MAX = '1;

  logic [PIX_W-1:0] pixCnt, lineLen;
  logic [PIX_W-1:0] openA, shutA, openC, shutC, endA, endC;
  logic hdSeen;
  logic inA, inC;

  // Horizontal bounds per standard and sensor width
  always_comb begin
    unique case ({strb.ccir, strb.wide})
      2'b00: begin
        openA = PIX_W'(104); shutA = PIX_W'(3);
        openC = PIX_W'(272); shutC = PIX_W'(167);
      end
      2'b01: begin
        openA = PIX_W'(154); shutA = PIX_W'(22);
        openC = PIX_W'(407); shutC = PIX_W'(252);
      end
      2'b10: begin
        openA = PIX_W'(114); shutA = PIX_W'(3);
        openC = PIX_W'(279); shutC = PIX_W'(164);
      end
      default: begin
        openA = PIX_W'(169); shutA = PIX_W'(22);
        openC = PIX_W'(416); shutC = PIX_W'(246);
      end
    endcase
  end

  // Closing points are counted back from the measured line length
  always_comb begin
    endA = (lineLen > shutA) ? lineLen - shutA : '0;
    endC = (lineLen > shutC) ? lineLen - shutC : '0;
    inA  = (pixCnt >= openA) && (pixCnt < endA);
    inC  = (pixCnt >= openC) && (pixCnt < endC);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixCnt  <= '0;
      lineLen <= '0;
      hdSeen  <= 1'b0;
      lenOk   <= 1'b0;
      winOut  <= 1'b0;
    end else begin
      if (strb.hdFall) begin
        pixCnt  <= '0;
        lineLen <= (pixCnt == PIX_MAX) ? PIX_MAX : pixCnt + 1'b1;
        hdSeen  <= 1'b1;
        if (hdSeen) begin
          lenOk <= 1'b1;
        end
      end else if (pixCnt != PIX_MAX) begin
        pixCnt <= pixCnt + 1'b1;
      end
      winOut <= lenOk & ((strb.enA & inA) | (strb.enC & inC));
    end
  end

endmodule

// File: rtl/meter_win.sv
module meter_win
  import meter_win_pkg::*;
#(
  parameter int PIX_W        = 11,
  parameter int LINE_W       = 10,
  parameter int EIA_FULL_LN  = 20,
  parameter int EIA_MID_BEG  = 101,
  parameter int EIA_MID_END  = 181,
  parameter int CCIR_FULL_LN = 25,
  parameter int CCIR_MID_BEG = 121,
  parameter int CCIR_MID_END = 216
) (
  input  logic clk,
  input  logic rstN,
  input  logic hdIn,
  input  logic vdIn,
  input  logic fieldEven,
  input  logic stdCcir,
  input  logic wideSensor,
  input  logic selBottom,
  input  logic selCenter,
  output logic winOut
);

  winStrb_t strb;
  logic     lenOk;

  meter_win_ctl #(
    .LINE_W      (LINE_W),
    .EIA_FULL_LN (EIA_FULL_LN),
    .EIA_MID_BEG (EIA_MID_BEG),
    .EIA_MID_END (EIA_MID_END),
    .CCIR_FULL_LN(CCIR_FULL_LN),
    .CCIR_MID_BEG(CCIR_MID_BEG),
    .CCIR_MID_END(CCIR_MID_END)
  ) u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .hdIn      (hdIn),
    .vdIn      (vdIn),
    .fieldEven (fieldEven),
    .stdCcir   (stdCcir),
    .wideSensor(wideSensor),
    .selBottom (selBottom),
    .selCenter (selCenter),
    .strb      (strb)
  );

  meter_win_dp #(
    .PIX_W(PIX_W)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .lenOk (lenOk),
    .winOut(winOut)
  );

endmodule

// File: rtl/meter_win_chk.sv
module meter_win_chk
  import meter_win_pkg::*;
(
  input logic     clk,
  input logic     rstN,
  input logic     vdIn,
  input winStrb_t strb,
  input logic     lenOk,
  input logic     winOut
);

  logic vdPrev;
  logic vdEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vdPrev <= 1'b1;
    else       vdPrev <= vdIn;
  end
  assign vdEdge = vdPrev & ~vdIn;

  // R1: reset holds the pulse low
  p_reset_low_r1: assert property (@(posedge clk) !rstN |-> !winOut);

  // R9: no pulse until a line length has been measured
  p_len_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    !lenOk |=> !winOut);

  // R3: a new field closes the window (line bounds are at least one)
  p_vd_closes_r3: assert property (@(posedge clk) disable iff (!rstN)
    vdEdge |=> ##1 !winOut);

  // R7: the start of a line is never inside a horizontal bound
  p_line_start_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.hdFall |=> ##1 !winOut);

  // R2: the pulse only follows a selected vertical qualifier
  p_needs_enable_r2: assert property (@(posedge clk) disable iff (!rstN)
    winOut |-> $past(strb.enA || strb.enC));

endmodule

bind meter_win meter_win_chk u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .vdIn  (vdIn),
  .strb  (strb),
  .lenOk (lenOk),
  .winOut(winOut)
);

// File: tb/sim_meter_win.sv
module sim_meter_win;

  // Reduced vertical bounds so a whole field is a few lines
  localparam int EF = 1, EB = 2, EE = 4;
  localparam int CF = 2, CB = 3, CE = 5;
  localparam int LINE_LEN = 680;
  localparam int LINES = 7;
  localparam int HD_W = 32;
  localparam int VD_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hdIn = 1'b1, vdIn = 1'b1;
  logic fieldEven = 1'b0, stdCcir = 1'b0, wideSensor = 1'b0;
  logic selBottom = 1'b0, selCenter = 1'b0;
  logic winOut;

  // configuration to apply with the next position
  logic nHalf = 1'b0, nCcir = 1'b0, nWide = 1'b0, nSb = 1'b0, nSc = 1'b0;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  // bench model state
  bit prevHd = 1'b1, prevVd = 1'b1;
  int mp = 0, mlc = 0, falls = 0, primed = 0;
  bit e1 = 1'b0, e2 = 1'b0;
  string t1 = "R9", t2 = "R9";

  always #4 clk = ~clk;

  meter_win #(
    .PIX_W(11), .LINE_W(10),
    .EIA_FULL_LN(EF), .EIA_MID_BEG(EB), .EIA_MID_END(EE),
    .CCIR_FULL_LN(CF), .CCIR_MID_BEG(CB), .CCIR_MID_END(CE)
  ) u0 (
    .clk(clk), .rstN(rstN), .hdIn(hdIn), .vdIn(vdIn),
    .fieldEven(fieldEven), .stdCcir(stdCcir), .wideSensor(wideSensor),
    .selBottom(selBottom), .selCenter(selCenter), .winOut(winOut)
  );

  always @(posedge clk) cyc <= cyc + 1;

  function automatic void hBounds(input bit ccir, input bit wide, input bit mid,
                                  output int op, output int cl);
    case ({ccir, wide, mid})
      3'b000: begin op = 104; cl = 3;   end
      3'b010: begin op = 154; cl = 22;  end
      3'b100: begin op = 114; cl = 3;   end
      3'b110: begin op = 169; cl = 22;  end
      3'b001: begin op = 272; cl = 167; end
      3'b011: begin op = 407; cl = 252; end
      3'b101: begin op = 279; cl = 164; end
      default: begin op = 416; cl = 246; end
    endcase
  endfunction

  task automatic model(output bit e, output string tag);
    int oa, ca, oc, cc, f, b, en;
    bit hA, hC, vF, vM, vL;
    hBounds(stdCcir, wideSensor, 1'b0, oa, ca);
    hBounds(stdCcir, wideSensor, 1'b1, oc, cc);
    f  = (stdCcir ? CF : EF) + int'(fieldEven);
    b  = (stdCcir ? CB : EB) + int'(fieldEven);
    en = (stdCcir ? CE : EE) + int'(fieldEven);
    hA = (mp >= oa) && (mp < LINE_LEN - ca);
    hC = (mp >= oc) && (mp < LINE_LEN - cc);
    vF = mlc >= f;
    vM = (mlc >= b) && (mlc < en);
    vL = mlc >= en;
    if (falls < 2) begin
      e = 1'b0; tag = "R9";
    end else begin
      case ({selCenter, selBottom})
        2'b00: begin e = vF & hA; tag = vF ? "R7" : "R2,R3"; end
        2'b01: begin e = vL & hA; tag = vL ? "R7" : "R2,R5"; end
        2'b10: begin e = vM & hC; tag = vM ? "R8" : "R2,R4"; end
        default: begin e = (vL & hA) | (vM & hC); tag = "R2,R6"; end
      endcase
    end
  endtask

  // One clock: compare the result for the position two cycles back,
  // then drive the next position and model it.
  task automatic step(input logic hd, input logic vd);
    bit hf, vf;
    @(negedge clk);
    if (primed >= 2) begin
      checks++;
      if (winOut !== e2) begin
        fails++;
        $display("FAIL %s: winOut=%0b expected %0b (cycle %0d)", t2, winOut, e2, cyc);
      end
    end
    e2 = e1; t2 = t1;
    hdIn = hd; vdIn = vd;
    fieldEven = nHalf; stdCcir = nCcir; wideSensor = nWide;
    selBottom = nSb; selCenter = nSc;
    hf = prevHd & !hd;
    vf = prevVd & !vd;
    prevHd = hd; prevVd = vd;
    if (hf) begin mp = 0; if (falls < 2) falls++; end
    else mp++;
    if (vf) mlc = 0;
    else if (hf) mlc++;
    model(e1, t1);
    primed++;
  endtask

  task automatic runLines(input bit half, input int nLines, input int lastPos);
    int vdPos;
    vdPos = half ? LINE_LEN / 2 : 0;
    for (int ln = 0; ln < nLines; ln++) begin
      for (int p = 0; p < LINE_LEN; p++) begin
        if (ln == nLines - 1 && p > lastPos) break;
        step(!(p < HD_W), !(ln == 0 && p >= vdPos && p < vdPos + VD_W));
      end
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    // R1: reset state
    repeat (4) begin
      @(negedge clk);
      hdIn = ~hdIn;
      checks++;
      if (winOut !== 1'b0) begin
        fails++;
        $display("FAIL R1: winOut=%0b expected 0 during reset", winOut);
      end
    end
    @(negedge clk);
    hdIn = 1'b1;
    @(negedge clk);
    rstN = 1'b1;

    // Sweep: standard x sensor x window kind x field
    for (int combo = 0; combo < 4; combo++) begin
      for (int fld = 0; fld < 8; fld++) begin
        nCcir = combo[1];
        nWide = combo[0];
        nSb   = fld[1];
        nSc   = fld[2];
        nHalf = fld[0];
        runLines(fld[0], LINES, LINE_LEN - 1);
      end
    end

    // Stop inside an open whole-picture window, then reset (R1)
    nSb = 1'b0; nSc = 1'b0; nHalf = 1'b0;
    runLines(1'b0, 4, 300);
    step(1'b1, 1'b1);
    step(1'b1, 1'b1);
    @(negedge clk);
    checks++;
    if (winOut !== 1'b1) begin
      fails++;
      $display("FAIL R3: winOut=%0b expected 1 before reset", winOut);
    end
    rstN = 1'b0;
    #1;
    checks++;
    if (winOut !== 1'b0) begin
      fails++;
      $display("FAIL R1: winOut=%0b expected 0 right after reset", winOut);
    end
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R9: watchdog, run still active (actual running, expected finished)");
      summary();
    end
  end

endmodule